// File: doc/BRIEF.md
# DRAM Parallel Test Mode Controller

This block models the control logic and data path of a small asynchronous DRAM that has a compressed parallel test mode. The active-low row strobe, column strobe and write enable come in asynchronously. They pass through a synchronizer on a fast system clock, and an edge detector turns their transitions into single-cycle pulses. The order in which the strobes change classifies each cycle into one of four kinds:

- an ordinary access,
- a write-and-column-before-row cycle, which enters test mode,
- a column-before-row refresh,
- a row-only refresh.

The row address is latched when the row strobe falls. The column address is latched on every column strobe fall inside an access, so page-mode bursts work.

In normal mode each access reads or writes one cell of a small internal array. In test mode the two lowest column bits are ignored. A write then copies every data bit into a group of four cells. A read returns, for each I/O, a flag that is high when the four cells agree. A data-valid output marks when the read data may be used; at all other times the data output is parked at zero.

Top module: `ptm_dram_ctrl`

## Requirements
- R1: Strobe pins go through a two-stage synchronizer and an edge register. A row strobe fall that is applied before clock edge 1 updates the mode flag at edge 3, and not earlier.
- R2: If the row strobe falls while the column strobe and write enable are both already low, the test-mode flag is set and `cyc_kind` reads 2.
- R3: If the row strobe falls while the column strobe is low and write enable is high, the test-mode flag is cleared and `cyc_kind` reads 3.
- R4: If the row strobe falls with the column strobe high and then rises with no column strobe fall in between, the test-mode flag is cleared and `cyc_kind` reads 4. A column fall that is detected in the same clock as the row rise does not count as an access.
- R5: In normal mode a write stores `din` into the single cell at the latched row and the full column. A read returns that cell. An access cycle reads `cyc_kind` = 1.
- R6: Within one row strobe low period, each column strobe fall latches a new column, so several cells are written or read in page mode.
- R7: In test mode a write stores `din` into all four cells that share the row and the column bits above bit 1. Column bits 1:0 are ignored.
- R8: In test mode a read sets `dout[i]` to 1 when bit i of all four cells in the group is equal, and to 0 otherwise.
- R9: In test mode, a normal read cycle leaves the flag set, and a further write-and-column-before-row cycle keeps it set.
- R10: `dout_vld` is high only while the synchronized row and column strobes are low and write enable is high within an access with a latched column. Otherwise it is 0 and `dout` is 0.
- R11: Reset clears the test-mode flag, returns `cyc_kind` to 0, and drops `dout_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | IO_W | Write data, one bit per I/O |
| dout | output | IO_W | Cell data or per-I/O compare result |
| dout_vld | output | 1 | Read data valid window |
| test_mode | output | 1 | Parallel test mode flag |
| cyc_kind | output | 3 | Last decoded cycle: 0 idle, 1 access, 2 test entry, 3 column-first refresh, 4 row-only refresh |

## Verification
A row strobe rise and a column strobe fall can land in the same sampling clock. This forces the decoder to choose between closing the cycle as a row-only refresh and opening a column access. The bench provokes this by releasing the row strobe and asserting the column strobe in the same time step while the device is in test mode. It then judges the outcome from the mode flag and the cycle kind: the device must leave test mode, and no access must be recorded.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE    = 3'd0,
    CYC_ACCESS  = 3'd1,
    CYC_TSTENT  = 3'd2,
    CYC_COLREF  = 3'd3,
    CYC_ROWREF  = 3'd4
  } cyc_kind_e;

  localparam int GRP_BITS = 2;
endpackage

// File: rtl/ptm_strobe_sync.sv
module ptm_strobe_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] lvl_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_strb
    logic s1_q, s2_q, prv_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q  <= 1'b1;
        s2_q  <= 1'b1;
        prv_q <= 1'b1;
      end else begin
        s1_q  <= pin_n[i];
        s2_q  <= s1_q;
        prv_q <= s2_q;
      end
    end

    assign lvl_n[i] = s2_q;
    assign fall[i]  = prv_q & ~s2_q;
    assign rise[i]  = ~prv_q & s2_q;
  end
endmodule

// File: rtl/ptm_cycle_dec.sv
module ptm_cycle_dec
  import ptm_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int IO_W   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_s,
  input  logic              cas_s,
  input  logic              we_s,
  input  logic              ras_fall,
  input  logic              ras_rise,
  input  logic              cas_fall,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IO_W-1:0]   din,
  output logic              test_mode,
  output cyc_kind_e         kind,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic              wr_en,
  output logic [IO_W-1:0]   wr_data,
  output logic              rd_window
);
  logic             tm_q, tm_d;
  cyc_kind_e        kind_q, kind_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             seen_q, seen_d;
  logic             wr_q, wr_d;
  logic [IO_W-1:0]  wdat_q, wdat_d;

  always_comb begin
    tm_d   = tm_q;
    kind_d = kind_q;
    row_d  = row_q;
    col_d  = col_q;
    seen_d = seen_q;
    wr_d   = 1'b0;
    wdat_d = wdat_q;
    if (ras_fall) begin
      seen_d = 1'b0;
      if (!cas_s) begin
        if (!we_s) begin
          tm_d   = 1'b1;
          kind_d = CYC_TSTENT;
        end else begin
          tm_d   = 1'b0;
          kind_d = CYC_COLREF;
        end
      end else begin
        kind_d = CYC_ACCESS;
        row_d  = addr[ROW_W-1:0];
      end
    end else if (ras_rise) begin
      if (kind_q == CYC_ACCESS && !seen_q) begin
        tm_d   = 1'b0;
        kind_d = CYC_ROWREF;
      end
    end else if (cas_fall && !ras_s && kind_q == CYC_ACCESS) begin
      seen_d = 1'b1;
      col_d  = addr[COL_W-1:0];
      if (!we_s) begin
        wr_d   = 1'b1;
        wdat_d = din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_q   <= 1'b0;
      kind_q <= CYC_IDLE;
      row_q  <= '0;
      col_q  <= '0;
      seen_q <= 1'b0;
      wr_q   <= 1'b0;
      wdat_q <= '0;
    end else begin
      tm_q   <= tm_d;
      kind_q <= kind_d;
      row_q  <= row_d;
      col_q  <= col_d;
      seen_q <= seen_d;
      wr_q   <= wr_d;
      wdat_q <= wdat_d;
    end
  end

  assign test_mode = tm_q;
  assign kind      = kind_q;
  assign row       = row_q;
  assign col       = col_q;
  assign wr_en     = wr_q;
  assign wr_data   = wdat_q;
  assign rd_window = ~ras_s & ~cas_s & we_s & seen_q & (kind_q == CYC_ACCESS);

  // R2
  tm_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_s && !we_s) |=> (test_mode && kind == CYC_TSTENT));
  // R3
  tm_colref_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_s && we_s) |=> (!test_mode && kind == CYC_COLREF));
  // R4
  tm_rowref_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_rise && kind == CYC_ACCESS && !seen_q) |=> (!test_mode && !wr_en));
endmodule

// File: rtl/ptm_cell_array.sv
module ptm_cell_array
  import ptm_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int IO_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             test_mode,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [IO_W-1:0]  wr_data,
  output logic [IO_W-1:0]  rd_data
);
  localparam int AW    = ROW_W + COL_W;
  localparam int DEPTH = 1 << AW;
  localparam int GB    = GRP_BITS;
  localparam int GRP   = 1 << GB;

  logic [IO_W-1:0] mem [DEPTH];
  logic [IO_W-1:0] cmp;
  logic [AW-1:0]   idx;

  assign idx = {row, col};

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (test_mode) begin
        for (int g = 0; g < GRP; g++) begin
          mem[{row, col[COL_W-1:GB], GB'(g)}] <= wr_data;
        end
      end else begin
        mem[idx] <= wr_data;
      end
    end
  end

  for (genvar i = 0; i < IO_W; i++) begin : g_bit
    logic [GRP-1:0] cells;
    always_comb begin
      for (int g = 0; g < GRP; g++) begin
        cells[g] = mem[{row, col[COL_W-1:GB], GB'(g)}][i];
      end
    end
    assign cmp[i] = (&cells) | (~|cells);
  end

  assign rd_data = test_mode ? cmp : mem[idx];

  // R7
  fill_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && test_mode) |=> (cmp == '1));
endmodule

// File: rtl/ptm_dram_ctrl.sv
module ptm_dram_ctrl
  import ptm_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int IO_W  = 4,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IO_W-1:0]   din,
  output logic [IO_W-1:0]   dout,
  output logic              dout_vld,
  output logic              test_mode,
  output logic [2:0]        cyc_kind
);
  logic [2:0]       lvl_n, fall, rise;
  logic             wr_en, rd_window;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [IO_W-1:0]  wr_data, rd_data;
  cyc_kind_e        kind;

  ptm_strobe_sync #(.N(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n ({we_n, cas_n, ras_n}),
    .lvl_n (lvl_n),
    .fall  (fall),
    .rise  (rise)
  );

  ptm_cycle_dec #(
    .ROW_W(ROW_W), .COL_W(COL_W), .IO_W(IO_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_s     (lvl_n[0]),
    .cas_s     (lvl_n[1]),
    .we_s      (lvl_n[2]),
    .ras_fall  (fall[0]),
    .ras_rise  (rise[0]),
    .cas_fall  (fall[1]),
    .addr      (addr),
    .din       (din),
    .test_mode (test_mode),
    .kind      (kind),
    .row       (row),
    .col       (col),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_window (rd_window)
  );

  ptm_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .IO_W(IO_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .test_mode (test_mode),
    .row       (row),
    .col       (col),
    .wr_data   (wr_data),
    .rd_data   (rd_data)
  );

  assign dout_vld = rd_window;
  assign dout     = rd_window ? rd_data : '0;
  assign cyc_kind = kind;

  // R10
  vld_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> (!$past(ras_n, 2) && !$past(cas_n, 2) && $past(we_n, 2)));
  // R10
  dout_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> (dout == '0));
  // R5
  no_wr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> !wr_en);
endmodule

// File: tb/ptm_dram_ctrl_bench.sv
module ptm_dram_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, ras_n, cas_n, we_n;
  logic [3:0] addr, din, dout;
  logic       dout_vld, test_mode;
  logic [2:0] cyc_kind;

  int n_chk  = 0;
  int n_fail = 0;

  // {row, col, data}
  localparam logic [11:0] VEC [6] = '{
    12'h135, 12'h14A, 12'h70F, 12'hFF0, 12'h006, 12'hF09
  };

  ptm_dram_ctrl u_ptm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld),
    .test_mode(test_mode), .cyc_kind(cyc_kind)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ras_open(input logic [3:0] r);
    addr = r; ras_n = 1'b0; cyc(4);
  endtask

  task automatic ras_close();
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; cyc(4);
  endtask

  task automatic cas_wr(input logic [3:0] c, input logic [3:0] d);
    addr = c; din = d; we_n = 1'b0; cas_n = 1'b0; cyc(5);
    chk("R10 no valid during write", {7'd0, dout_vld}, 8'd0);
    cas_n = 1'b1; we_n = 1'b1; cyc(3);
  endtask

  task automatic cas_rd(input logic [3:0] c, output logic [3:0] d, output logic v);
    addr = c; we_n = 1'b1; cas_n = 1'b0; cyc(4);
    d = dout; v = dout_vld;
    cas_n = 1'b1; cyc(3);
  endtask

  task automatic enter_test();
    we_n = 1'b0; cas_n = 1'b0; cyc(4);
    ras_n = 1'b0; cyc(4);
    ras_close();
  endtask

  task automatic col_refresh();
    we_n = 1'b1; cas_n = 1'b0; cyc(4);
    ras_n = 1'b0; cyc(4);
    ras_close();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] d;
    logic       v;
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
    cyc(4);
    // R11 reset state
    chk("R11 test_mode after reset", {7'd0, test_mode}, 8'd0);
    chk("R11 kind after reset", {5'd0, cyc_kind}, 8'd0);
    chk("R11 valid after reset", {7'd0, dout_vld}, 8'd0);
    rst_n = 1'b1; cyc(2);

    // R5 table walk: write all, then read all
    for (int i = 0; i < 6; i++) begin
      ras_open(VEC[i][11:8]);
      cas_wr(VEC[i][7:4], VEC[i][3:0]);
      ras_close();
    end
    for (int i = 0; i < 6; i++) begin
      ras_open(VEC[i][11:8]);
      cas_rd(VEC[i][7:4], d, v);
      chk("R5 normal read data", {4'd0, d}, {4'd0, VEC[i][3:0]});
      chk("R10 valid in read", {7'd0, v}, 8'd1);
      chk("R5 access kind", {5'd0, cyc_kind}, 8'd1);
      ras_close();
      chk("R10 valid after close", {7'd0, dout_vld}, 8'd0);
    end

    // R6 page mode
    ras_open(4'h3);
    cas_wr(4'h8, 4'h3);
    cas_wr(4'h9, 4'hC);
    ras_close();
    ras_open(4'h3);
    cas_rd(4'h8, d, v);
    chk("R6 page read col8", {4'd0, d}, 8'h03);
    cas_rd(4'h9, d, v);
    chk("R6 page read col9", {4'd0, d}, 8'h0C);
    ras_close();

    // R1 timing and R2 entry
    we_n = 1'b0; cas_n = 1'b0; cyc(4);
    ras_n = 1'b0; cyc(2);
    chk("R1 flag not set after two edges", {7'd0, test_mode}, 8'd0);
    cyc(1);
    chk("R1 flag set at third edge", {7'd0, test_mode}, 8'd1);
    chk("R2 entry kind", {5'd0, cyc_kind}, 8'd2);
    cyc(1);
    ras_close();

    // R7 test write, R8 pass read
    ras_open(4'h2);
    cas_wr(4'h5, 4'hA);
    cas_rd(4'h6, d, v);
    chk("R8 test read all equal", {4'd0, d}, 8'h0F);
    chk("R10 valid in test read", {7'd0, v}, 8'd1);
    ras_close();
    // R9 read cycle and re-entry keep test mode
    chk("R9 flag after test read cycle", {7'd0, test_mode}, 8'd1);
    enter_test();
    chk("R9 flag after repeated entry", {7'd0, test_mode}, 8'd1);

    // R3 exit by column-first refresh
    col_refresh();
    chk("R3 flag cleared", {7'd0, test_mode}, 8'd0);
    chk("R3 kind", {5'd0, cyc_kind}, 8'd3);

    // R7 check group contents in normal mode
    for (int c = 4; c < 8; c++) begin
      ras_open(4'h2);
      cas_rd(4'(c), d, v);
      chk("R7 group cell", {4'd0, d}, 8'h0A);
      ras_close();
    end

    // R8 mismatch on bit 0
    ras_open(4'h2);
    cas_wr(4'h7, 4'hB);
    ras_close();
    enter_test();
    ras_open(4'h2);
    cas_rd(4'h4, d, v);
    chk("R8 test read with bit0 mismatch", {4'd0, d}, 8'h0E);
    ras_close();

    // R4 row-only refresh exit
    ras_open(4'h1);
    ras_close();
    chk("R4 flag cleared", {7'd0, test_mode}, 8'd0);
    chk("R4 kind", {5'd0, cyc_kind}, 8'd4);

    // R4 corner: row rise and column fall together
    enter_test();
    ras_open(4'h0);
    ras_n = 1'b1; cas_n = 1'b0; cyc(4);
    chk("R4 simultaneous edge flag", {7'd0, test_mode}, 8'd0);
    chk("R4 simultaneous edge kind", {5'd0, cyc_kind}, 8'd4);
    cas_n = 1'b1; cyc(4);

    // R11 reset while in test mode
    enter_test();
    chk("R2 flag before reset", {7'd0, test_mode}, 8'd1);
    rst_n = 1'b0; cyc(2);
    chk("R11 flag cleared by reset", {7'd0, test_mode}, 8'd0);
    chk("R11 kind cleared by reset", {5'd0, cyc_kind}, 8'd0);
    rst_n = 1'b1; cyc(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule